// File: doc/BRIEF.md
# Byte-Wide SPI Port with Selectable Select-Line Modes

This block is a single-byte serial peripheral interface port that works either as the bus master or as a slave. A simple register-style interface sets the enable, the role, a two-bit select-line mode and a clock divider. The same interface writes the transmit byte, reads the received byte and clears the sticky status flags. The pads are modelled as separate output values and output enables for the data-out, data-in, clock and select lines, so a tri-state pad ring can be attached directly.

The select-line mode decides how the select pin is used. In mode 00 (3-wire) the pin is not used at all, and a slave always counts as selected. In mode 01 the pin is an input. It chooses the device when the port is a slave. When the port is a master, a falling level on it signals that another master has taken the bus: the port raises a mode-fault flag, drops out of the master role and releases its drivers. In modes 10 and 11 the pin is a driven output whose level is the low mode bit. These two modes are meant for the master role only.

In the master role the serial clock comes from a programmable divider. The clock idles low. Data is sampled on the rising edge and changed on the falling edge. In the slave role the incoming clock and select are resynchronised to the system clock and their edges are detected there, so the system clock must run at least four times faster than the serial clock.

Top module: `spi_port`

## Requirements
- R1: Data moves most-significant bit first. As master, `mosi_o` is always bit 7 of the shift register. `sck_o` idles at 0 and toggles every `ctrl_div`+1 system clocks during a transfer. `miso_i` is sampled on the rising edge and the shift happens on the falling edge.
- R2: After the eighth falling edge, `done_flag` is set and `rx_data` takes the received byte in the same cycle. `busy` returns to 0 at that point. `flag_clr` clears `done_flag`, `wcol_flag` and `modf_flag`.
- R3: A `tx_wr` while `busy` is 1 sets `wcol_flag` and leaves the byte being shifted unchanged.
- R4: `miso_oe` is 0 while the port is disabled. It is also 0 while the port is a mode-01 slave whose synchronised `nss_i` is high.
- R5: A mode-00 slave is always selected. It drives `miso_oe`=1 and sends the byte written by `tx_wr` on `miso_o`, MSB first. It captures `mosi_i` on rising edges of `sck_i`.
- R6: A mode-01 slave ignores `sck_i` edges while `nss_i` is high. Such edges neither start a transfer nor shift any bit.
- R7: In mode 00, `nss_oe` stays 0.
- R8: In modes 10 and 11, an enabled master drives `nss_oe`=1, and `nss_o` equals the low mode bit (10 gives 0, 11 gives 1).
- R9: An enabled mode-01 master that sees a falling `nss_i` does four things: it sets `modf_flag`, clears `master_act`, aborts the transfer (`busy`=0, `sck_o`=0) and drops `mosi_oe` and `sck_oe`.
- R10: `mosi_oe` and `sck_oe` are 1 exactly when the port is enabled and acting as master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control fields; also cancels any transfer |
| ctrl_en | input | 1 | Enable value written on ctrl_wr |
| ctrl_master | input | 1 | 1 selects master role |
| ctrl_sel | input | 2 | Select-line mode (00, 01, 1x) |
| ctrl_div | input | DIV_W | Half-period divider; half period is ctrl_div+1 clocks |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Transmit byte |
| flag_clr | input | 1 | Clears the three sticky flags |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Transfer in progress |
| done_flag | output | 1 | Sticky transfer-complete flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| modf_flag | output | 1 | Sticky mode-fault flag |
| master_act | output | 1 | Current master-role bit |
| mosi_o | output | 1 | Master data out value |
| mosi_oe | output | 1 | Master data out enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out value |
| miso_oe | output | 1 | Slave data out enable |
| miso_i | input | 1 | Master data in |
| sck_o | output | 1 | Serial clock out value |
| sck_oe | output | 1 | Serial clock out enable |
| sck_i | input | 1 | Serial clock in (slave) |
| nss_o | output | 1 | Select line out value |
| nss_oe | output | 1 | Select line out enable |
| nss_i | input | 1 | Select line in |

## Verification
The assertions assume that `sck_i` and `nss_i` change slowly enough for the two-flop synchroniser to follow. They also assume that `nss_i` stays high while the port is a mode-01 master, unless a mode fault is being exercised on purpose. The bench keeps to both assumptions. When it acts as master it holds every serial-clock phase for eight system clocks, well above the four-to-one minimum. It holds `nss_i` high outside the select tests, and it pulls the line low only once, in the mode-fault case, while a master transfer is in progress.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DIV_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_en,
  input  logic             ctrl_master,
  input  logic [1:0]       ctrl_sel,
  input  logic [DIV_W-1:0] ctrl_div,
  input  logic             tx_wr,
  input  logic [DW-1:0]    tx_data,
  input  logic             flag_clr,
  output logic [DW-1:0]    rx_data,
  output logic             busy,
  output logic             done_flag,
  output logic             wcol_flag,
  output logic             modf_flag,
  output logic             master_act,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             sck_i,
  output logic             nss_o,
  output logic             nss_oe,
  input  logic             nss_i
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic             en_q, mst_q, sck_q, samp;
  logic [1:0]       mode_q;
  logic [DIV_W-1:0] div_q, div_cnt;
  logic [DW-1:0]    shreg;
  logic [CW-1:0]    bit_cnt;
  logic [2:0]       sck_sync, nss_sync;

  wire sck_rise   = sck_sync[1] & ~sck_sync[2];
  wire sck_fall   = ~sck_sync[1] & sck_sync[2];
  wire nss_lvl    = nss_sync[1];
  wire nss_fall   = ~nss_sync[1] & nss_sync[2];
  wire is_master  = en_q & mst_q;
  wire sl_sel     = en_q & ~mst_q & ((mode_q == 2'b00) | ((mode_q == 2'b01) & ~nss_lvl));
  wire mode_fault = is_master & (mode_q == 2'b01) & nss_fall;
  wire half_done  = div_cnt == div_q;
  wire [DW-1:0] shifted = {shreg[DW-2:0], samp};

  assign master_act = mst_q;
  assign sck_o      = sck_q;
  assign sck_oe     = is_master;
  assign mosi_o     = shreg[DW-1];
  assign mosi_oe    = is_master;
  assign miso_o     = shreg[DW-1];
  assign miso_oe    = sl_sel;
  assign nss_o      = mode_q[0];
  assign nss_oe     = is_master & mode_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync <= '0;
      nss_sync <= '1;
    end else begin
      sck_sync <= {sck_sync[1:0], sck_i};
      nss_sync <= {nss_sync[1:0], nss_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      mst_q     <= 1'b0;
      mode_q    <= 2'b00;
      div_q     <= '0;
      div_cnt   <= '0;
      shreg     <= '0;
      bit_cnt   <= '0;
      samp      <= 1'b0;
      sck_q     <= 1'b0;
      busy      <= 1'b0;
      rx_data   <= '0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
      modf_flag <= 1'b0;
    end else begin
      if (flag_clr) begin
        done_flag <= 1'b0;
        wcol_flag <= 1'b0;
        modf_flag <= 1'b0;
      end
      if (ctrl_wr) begin
        en_q    <= ctrl_en;
        mst_q   <= ctrl_master;
        mode_q  <= ctrl_sel;
        div_q   <= ctrl_div;
        busy    <= 1'b0;
        bit_cnt <= '0;
        sck_q   <= 1'b0;
        div_cnt <= '0;
      end else if (!en_q) begin
        busy    <= 1'b0;
        bit_cnt <= '0;
        sck_q   <= 1'b0;
      end else if (mode_fault) begin
        mst_q     <= 1'b0;
        modf_flag <= 1'b1;
        busy      <= 1'b0;
        bit_cnt   <= '0;
        sck_q     <= 1'b0;
        div_cnt   <= '0;
      end else if (mst_q) begin
        if (busy) begin
          if (half_done) begin
            div_cnt <= '0;
            sck_q   <= ~sck_q;
            if (!sck_q) begin
              samp <= miso_i;
            end else begin
              shreg   <= shifted;
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST) begin
                busy      <= 1'b0;
                done_flag <= 1'b1;
                rx_data   <= shifted;
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
      end else begin
        if (!sl_sel) begin
          busy    <= 1'b0;
          bit_cnt <= '0;
        end else if (sck_rise) begin
          samp <= mosi_i;
          busy <= 1'b1;
        end else if (sck_fall && busy) begin
          shreg   <= shifted;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST) begin
            busy      <= 1'b0;
            done_flag <= 1'b1;
            rx_data   <= shifted;
          end
        end
      end
      if (tx_wr) begin
        if (busy) begin
          wcol_flag <= 1'b1;
        end else if (en_q && !ctrl_wr && !mode_fault) begin
          shreg <= tx_data;
          if (mst_q) begin
            busy    <= 1'b1;
            div_cnt <= '0;
            bit_cnt <= '0;
            sck_q   <= 1'b0;
          end
        end
      end
    end
  end

  // R3: a write during a transfer is flagged and leaves the shifted byte alone
  p_wcol_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && busy && !ctrl_wr) |=> (wcol_flag && $stable(shreg) || !busy));

  // R9: a mode fault ends master operation and the transfer
  p_modf_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && !ctrl_wr) |=> (modf_flag && !mst_q && !busy && !sck_q));

  // R6: a deselected 4-wire slave never starts counting
  p_slave_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !mst_q && mode_q == 2'b01 && nss_lvl && !ctrl_wr) |=> (!busy && bit_cnt == '0));

  // R1: the master clock stays low whenever no transfer runs
  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !sck_q);

  // R2: completion coincides with loading the read register
  p_done_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> (!busy && $past(busy)));

  // R8: a driven select output holds steady while the mode is unchanged
  p_nss_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nss_oe && $past(nss_oe) && !$past(ctrl_wr)) |-> $stable(nss_o));
endmodule

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;
  logic clk = 0, rst_n = 0;
  logic ctrl_wr = 0, ctrl_en = 0, ctrl_master = 0, tx_wr = 0, flag_clr = 0;
  logic [1:0] ctrl_sel = 0;
  logic [7:0] ctrl_div = 0, tx_data = 0;
  logic [7:0] rx_data;
  logic busy, done_flag, wcol_flag, modf_flag, master_act;
  logic mosi_o, mosi_oe, miso_o, miso_oe, sck_o, sck_oe, nss_o, nss_oe;
  logic mosi_i = 0, sck_i = 0, nss_i = 1;
  logic miso_i;

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  logic done_d = 0;
  logic finished = 0;

  logic [7:0] bs_sh, bs_cap, bs_val;
  logic bs_load = 0;

  always #4 clk = ~clk;

  spi_port u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
    .ctrl_master(ctrl_master), .ctrl_sel(ctrl_sel), .ctrl_div(ctrl_div),
    .tx_wr(tx_wr), .tx_data(tx_data), .flag_clr(flag_clr),
    .rx_data(rx_data), .busy(busy), .done_flag(done_flag), .wcol_flag(wcol_flag),
    .modf_flag(modf_flag), .master_act(master_act),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .nss_o(nss_o), .nss_oe(nss_oe), .nss_i(nss_i));

  // bench slave model used while the port is master
  assign miso_i = bs_sh[7];
  always @(negedge sck_o or posedge bs_load)
    if (bs_load) bs_sh <= bs_val;
    else bs_sh <= {bs_sh[6:0], 1'b0};
  always @(posedge sck_o) bs_cap <= {bs_cap[6:0], mosi_o};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: each completion pops one expected received byte
  always @(negedge clk) begin
    if (done_flag && !done_d) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected completion actual=%0h expected=none", rx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rx_data !== e) begin
          errors++;
          $display("FAIL R1/R2 rx_data actual=%0h expected=%0h", rx_data, e);
        end
      end
    end
    done_d = done_flag;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic en, logic m, logic [1:0] sel, logic [7:0] div);
    @(negedge clk);
    ctrl_en = en; ctrl_master = m; ctrl_sel = sel; ctrl_div = div; ctrl_wr = 1;
    @(negedge clk);
    ctrl_wr = 0;
  endtask

  task automatic clr();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic write_tx(logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic load_slave(logic [7:0] v);
    @(negedge clk); bs_val = v; bs_load = 1;
    @(negedge clk); bs_load = 0;
  endtask

  // driver: pushes expected byte, runs a master transfer, checks MOSI capture
  task automatic master_xfer(logic [7:0] tx, logic [7:0] sl);
    load_slave(sl);
    exp_q.push_back(sl);
    write_tx(tx);
    while (busy) @(negedge clk);
    cyc(2);
    chk("R1 mosi byte", bs_cap, tx);
    chk("R1 sck idle", sck_o, 0);
    clr();
  endtask

  // bench acting as master toward a slave-mode port
  task automatic slave_xfer(logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = mo[i];
      cyc(8);
      mi[i] = miso_o;
      sck_i = 1;
      cyc(8);
      sck_i = 0;
    end
    cyc(8);
  endtask

  initial begin
    logic [7:0] got;
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk("R10 reset sck_oe", sck_oe, 0);
    chk("R10 reset mosi_oe", mosi_oe, 0);
    chk("R4 reset miso_oe", miso_oe, 0);
    chk("R7 reset nss_oe", nss_oe, 0);
    chk("R2 reset flags", {busy, done_flag, wcol_flag, modf_flag, master_act}, 0);
    chk("R2 reset rx_data", rx_data, 0);

    cfg(1, 1, 2'b00, 8'd1);
    chk("R10 master sck_oe", sck_oe, 1);
    chk("R10 master mosi_oe", mosi_oe, 1);
    chk("R7 mode00 nss_oe", nss_oe, 0);
    chk("R4 master miso_oe", miso_oe, 0);
    master_xfer(8'hA5, 8'h3C);
    chk("R2 flag_clr done", done_flag, 0);

    cfg(1, 1, 2'b01, 8'd0);
    master_xfer(8'h81, 8'h7E);

    cfg(1, 1, 2'b10, 8'd3);
    chk("R8 mode10 nss_oe", nss_oe, 1);
    chk("R8 mode10 nss_o", nss_o, 0);
    master_xfer(8'h5A, 8'hC3);
    cfg(1, 1, 2'b11, 8'd3);
    chk("R8 mode11 nss_o", nss_o, 1);

    // R1 half-period timing, div=2
    cfg(1, 1, 2'b00, 8'd2);
    load_slave(8'h99);
    exp_q.push_back(8'h99);
    @(negedge clk); tx_data = 8'h66; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    chk("R1 sck low start", sck_o, 0);
    cyc(2);
    chk("R1 sck low before half", sck_o, 0);
    cyc(1);
    chk("R1 sck high at div+1", sck_o, 1);
    chk("R1 first bit msb", mosi_o, 0);
    // R3: collision during this transfer
    cyc(5);
    @(negedge clk); tx_data = 8'hFF; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    chk("R3 wcol set", wcol_flag, 1);
    while (busy) @(negedge clk);
    cyc(2);
    chk("R3 byte unchanged", bs_cap, 8'h66);
    clr();
    chk("R2 flag_clr wcol", wcol_flag, 0);

    // R9 mode fault
    cfg(1, 1, 2'b01, 8'd3);
    load_slave(8'h00);
    write_tx(8'hF0);
    cyc(10);
    nss_i = 0;
    cyc(5);
    chk("R9 modf set", modf_flag, 1);
    chk("R9 master cleared", master_act, 0);
    chk("R9 aborted busy", busy, 0);
    chk("R9 sck released", {sck_oe, mosi_oe, sck_o}, 0);
    chk("R9 no completion", done_flag, 0);
    nss_i = 1;
    cyc(4);
    clr();
    chk("R2 flag_clr modf", modf_flag, 0);

    // R5 3-wire slave
    cfg(1, 0, 2'b00, 8'd0);
    write_tx(8'h96);
    chk("R5 miso_oe 3-wire", miso_oe, 1);
    exp_q.push_back(8'h4B);
    slave_xfer(8'h4B, got);
    chk("R5 miso byte", got, 8'h96);
    clr();

    // R4 disabled
    cfg(0, 0, 2'b00, 8'd0);
    chk("R4 disabled miso_oe", miso_oe, 0);

    // R4/R6 4-wire slave
    cfg(1, 0, 2'b01, 8'd0);
    cyc(4);
    chk("R4 deselected miso_oe", miso_oe, 0);
    for (int k = 0; k < 3; k++) begin
      sck_i = 1; cyc(8); sck_i = 0; cyc(8);
    end
    chk("R6 ignored edges busy", busy, 0);
    chk("R6 ignored edges done", done_flag, 0);
    write_tx(8'h2D);
    nss_i = 0;
    cyc(4);
    chk("R4 selected miso_oe", miso_oe, 1);
    exp_q.push_back(8'hE1);
    slave_xfer(8'hE1, got);
    chk("R6 aligned miso byte", got, 8'h2D);
    nss_i = 1;
    cyc(4);
    chk("R4 released miso_oe", miso_oe, 0);

    cyc(4);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule